// File: doc/BRIEF.md
# Eight-Pin Configurable GPIO Controller

This block drives eight general-purpose pads from a small synchronous register bus with a 16-bit data word. Software picks a direction for each pin. For output pins it also picks a drive style, either push-pull or open-drain, and an output level. For pins that are not driving, it picks whether the pad is pulled down or left floating. The pad side of the block has three control vectors (data, output enable, pull-down enable) and takes one sampled input vector.

The true pad level can be read back at any time, even on pins the block is driving. The pads are sampled through a two-stage synchroniser, so this readback trails the pad by two clocks. The level-set register is write-only: a read of its address returns zero, and the pad level is seen only through the pad-level register. Reads are combinational on the address. Writes take effect on the clock edge at which write enable is high. The block takes an asynchronous active-low reset whose release is re-timed to the clock, so writes are accepted from the third rising edge after reset is released.

Top module: `gpio8_ctrl`

## Requirements
- R1: While reset is applied, and until the first accepted write, every pin is an input. That means pad_oe is 0x00, pad_out is 0x00 and pad_pd is 0xFF, and the drive, idle, direction and level-set storage are all zero.
- R2: Address 0x10 is the level-set register. Write bits 7:0 store one level per pin, with 1 for high and 0 for low. A read of 0x10 always returns 0x0000.
- R3: Address 0x11 is the direction register. Write bits 15:8 set the directions, with bit 8 for pin 0, 1 for output and 0 for input. A read returns the stored bits in 15:8 and zero in 7:0, and write bits 7:0 are ignored.
- R4: Address 0x12 is the drive-type register, one bit per pin in bits 7:0, with 1 for open-drain and 0 for push-pull. A read returns the stored bits with 15:8 zero.
- R5: An output pin in push-pull mode has pad_oe set to 1, and pad_out equals its level-set bit.
- R6: An output pin in open-drain mode has pad_out set to 0. Its pad_oe is 1 when its level-set bit is 0 and 0 when that bit is 1.
- R7: Address 0x13 is the idle-state register, bits 7:0, with 0 for pull-down and 1 for floating. A read returns the stored bits. pad_pd for a pin is 1 exactly when that pin's pad_oe is 0 and its idle bit is 0.
- R8: An input pin has pad_oe and pad_out both 0, whatever its level-set and drive-type bits hold.
- R9: A read of address 0x14 returns in bits 7:0 the pad_in value sampled two rising edges earlier, for input and output pins alike, with 15:8 zero.
- R10: Writes to 0x14 or to any address other than 0x10 to 0x13 change no register and no pad output. A read of any address other than 0x11 to 0x14 returns 0x0000.
- R11: A write changes the pad outputs right after the rising edge that captures it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Pad level seen at each pin |
| pad_out | output | 8 | Data driven toward each pad |
| pad_oe | output | 8 | Output enable per pad |
| pad_pd | output | 8 | Pull-down enable per pad |

## Verification
The assertions assume that the bus address and write strobe are stable and free of X around each rising edge. They also assume pad_in may change freely, but the readback property only applies once two edges have passed since internal reset was released. The bench changes every input shortly after a rising edge and samples halfway through the cycle, so no input moves near an edge. It waits out the re-timed reset before it issues any write, and its random phase keeps addresses in a window around the mapped range, so that unmapped writes and reads sit beside the real ones.

// File: rtl/gpio8_pkg.sv
`timescale 1ns/1ps
package gpio8_pkg;

  localparam logic [15:0] ADR_LVL_SET = 16'h0010;
  localparam logic [15:0] ADR_DIR     = 16'h0011;
  localparam logic [15:0] ADR_DRIVE   = 16'h0012;
  localparam logic [15:0] ADR_IDLE    = 16'h0013;
  localparam logic [15:0] ADR_PADLVL  = 16'h0014;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LVL_SET,
    SEL_DIR,
    SEL_DRIVE,
    SEL_IDLE,
    SEL_PADLVL
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [15:0] a);
    reg_sel_e s;
    unique case (a)
      ADR_LVL_SET: s = SEL_LVL_SET;
      ADR_DIR:     s = SEL_DIR;
      ADR_DRIVE:   s = SEL_DRIVE;
      ADR_IDLE:    s = SEL_IDLE;
      ADR_PADLVL:  s = SEL_PADLVL;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio8_rst_sync.sv
`timescale 1ns/1ps
module gpio8_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio8_regs.sv
`timescale 1ns/1ps
module gpio8_regs
  import gpio8_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  reg_sel_e            sel,
  input  logic                we,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] lvl_set_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] drive_q,
  output logic [NUM_PINS-1:0] idle_q
);
  localparam int unsigned DIR_LSB = DATA_W / 2;

  logic                en_lvl, en_dir, en_drive, en_idle;
  logic [NUM_PINS-1:0] lvl_d, dir_d, drive_d, idle_d;

  always_comb begin
    en_lvl   = we && (sel == SEL_LVL_SET);
    en_dir   = we && (sel == SEL_DIR);
    en_drive = we && (sel == SEL_DRIVE);
    en_idle  = we && (sel == SEL_IDLE);
    lvl_d    = wdata[NUM_PINS-1:0];
    dir_d    = wdata[DIR_LSB +: NUM_PINS];
    drive_d  = wdata[NUM_PINS-1:0];
    idle_d   = wdata[NUM_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_set_q <= '0;
      dir_q     <= '0;
      drive_q   <= '0;
      idle_q    <= '0;
    end else begin
      if (en_lvl)   lvl_set_q <= lvl_d;
      if (en_dir)   dir_q     <= dir_d;
      if (en_drive) drive_q   <= drive_d;
      if (en_idle)  idle_q    <= idle_d;
    end
  end
endmodule

// File: rtl/gpio8_in_sync.sv
`timescale 1ns/1ps
module gpio8_in_sync #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] d_i,
  output logic [NUM_PINS-1:0] q_o
);
  logic [NUM_PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [NUM_PINS-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio8_pin_drv.sv
`timescale 1ns/1ps
module gpio8_pin_drv #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] lvl_set,
  input  logic [NUM_PINS-1:0] dir,
  input  logic [NUM_PINS-1:0] drive,
  input  logic [NUM_PINS-1:0] idle,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pd
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic oe_b, out_b, pd_b;
    always_comb begin
      if (!dir[i]) begin
        oe_b  = 1'b0;
        out_b = 1'b0;
      end else if (drive[i]) begin
        oe_b  = ~lvl_set[i];
        out_b = 1'b0;
      end else begin
        oe_b  = 1'b1;
        out_b = lvl_set[i];
      end
      pd_b = ~oe_b & ~idle[i];
    end
    assign pad_oe[i]  = oe_b;
    assign pad_out[i] = out_b;
    assign pad_pd[i]  = pd_b;
  end
endmodule

// File: rtl/gpio8_ctrl.sv
`timescale 1ns/1ps
module gpio8_ctrl
  import gpio8_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pd
);
  localparam int unsigned DIR_LSB = DATA_W / 2;

  logic                rst_core_n;
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] lvl_set_q, dir_q, drive_q, idle_q, pad_lvl;

  gpio8_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_core_n)
  );

  assign sel = decode_addr(16'(bus_addr));

  gpio8_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sel       (sel),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .lvl_set_q (lvl_set_q),
    .dir_q     (dir_q),
    .drive_q   (drive_q),
    .idle_q    (idle_q)
  );

  gpio8_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (pad_in),
    .q_o   (pad_lvl)
  );

  gpio8_pin_drv #(.NUM_PINS(NUM_PINS)) u_drv (
    .lvl_set (lvl_set_q),
    .dir     (dir_q),
    .drive   (drive_q),
    .idle    (idle_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_pd  (pad_pd)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_DIR:    bus_rdata[DIR_LSB +: NUM_PINS] = dir_q;
      SEL_DRIVE:  bus_rdata[NUM_PINS-1:0]        = drive_q;
      SEL_IDLE:   bus_rdata[NUM_PINS-1:0]        = idle_q;
      SEL_PADLVL: bus_rdata[NUM_PINS-1:0]        = pad_lvl;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio8_ctrl_chk.sv
`timescale 1ns/1ps
module gpio8_ctrl_chk
  import gpio8_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_core_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_pd
);
  localparam int unsigned DIR_LSB = DATA_W / 2;

  logic [1:0] since_rst_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  // R1: quiet pads while the core is held in reset
  always @(posedge clk) begin
    if (!rst_core_n) begin
      a_r1_reset_pads: assert (pad_oe == '0 && pad_out == '0 && pad_pd == '1)
        else $error("a_r1_reset_pads");
    end
  end

  a_r2_lvlset_reads_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr == ADDR_W'(ADR_LVL_SET)) |-> (bus_rdata == '0));

  a_r3_dir_gates_oe: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == ADDR_W'(ADR_DIR))
      |=> ((pad_oe & ~$past(bus_wdata[DIR_LSB +: NUM_PINS])) == '0));

  a_r3_dir_low_byte_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr == ADDR_W'(ADR_DIR)) |-> (bus_rdata[DIR_LSB-1:0] == '0));

  a_r7_pd_not_while_driving: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((pad_pd & pad_oe) == '0));

  a_r9_readback_lag: assert property (@(posedge clk) disable iff (!rst_core_n)
    (since_rst_q >= 2'd2 && bus_addr == ADDR_W'(ADR_PADLVL))
      |-> (bus_rdata == DATA_W'($past(pad_in, 2))));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr < ADDR_W'(ADR_DIR) || bus_addr > ADDR_W'(ADR_PADLVL)) |-> (bus_rdata == '0));

  a_r10_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && (bus_addr < ADDR_W'(ADR_LVL_SET) || bus_addr > ADDR_W'(ADR_IDLE)))
      |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pd)));
endmodule

bind gpio8_ctrl gpio8_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pad_pd     (pad_pd)
);

// File: tb/tb_gpio8_ctrl.sv
`timescale 1ns/1ps
module tb_gpio8_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [7:0]  pad_in;
  logic [7:0]  pad_out, pad_oe, pad_pd;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  gpio8_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd(pad_pd)
  );

  // behavioural reference
  bit [7:0] m_lvl, m_dir, m_drv, m_idle;
  bit [7:0] m_hist [$];
  int       m_rcnt = 0;

  always @(posedge clk) begin
    if (!rst_n || m_rcnt < 2) begin
      if (!rst_n) m_rcnt = 0; else m_rcnt++;
      m_lvl = 0; m_dir = 0; m_drv = 0; m_idle = 0;
      m_hist = '{8'h00, 8'h00};
    end else begin
      m_hist.push_back(pad_in);
      void'(m_hist.pop_front());
      if (bus_we) begin
        case (bus_addr)
          8'h10: m_lvl  = bus_wdata[7:0];
          8'h11: m_dir  = bus_wdata[15:8];
          8'h12: m_drv  = bus_wdata[7:0];
          8'h13: m_idle = bus_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  function automatic bit [23:0] m_pads();
    bit [7:0] oe, out, pd;
    for (int i = 0; i < 8; i++) begin
      if (!m_dir[i])      begin oe[i] = 0;         out[i] = 0;        end
      else if (m_drv[i])  begin oe[i] = !m_lvl[i]; out[i] = 0;        end
      else                begin oe[i] = 1;         out[i] = m_lvl[i]; end
      pd[i] = !oe[i] && !m_idle[i];
    end
    return {out, oe, pd};
  endfunction

  function automatic bit [15:0] m_rd(input bit [7:0] a);
    case (a)
      8'h11: return {m_dir, 8'h00};
      8'h12: return {8'h00, m_drv};
      8'h13: return {8'h00, m_idle};
      8'h14: return {8'h00, m_hist.size() > 0 ? m_hist[0] : 8'h00};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison at the falling edge
  always @(negedge clk) begin
    bit [23:0] p;
    if (rst_n === 1'b1 && !done) begin
      p = m_pads();
      chk("R5 R6 R8 pad_out", {8'h00, pad_out}, {8'h00, p[23:16]});
      chk("R5 R6 R8 pad_oe",  {8'h00, pad_oe},  {8'h00, p[15:8]});
      chk("R7 pad_pd",        {8'h00, pad_pd},  {8'h00, p[7:0]});
      chk("R2 R3 R4 R7 R9 R10 read", bus_rdata, m_rd(bus_addr));
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    step();
    bus_we = 1'b0; bus_wdata = 16'h0000;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [15:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = 8'h00; bus_we = 1'b0; bus_wdata = 16'h0; pad_in = 8'h00;
    repeat (3) step();
    chk("R1 oe in reset", {8'h0, pad_oe}, 16'h0000);
    chk("R1 pd in reset", {8'h0, pad_pd}, 16'h00FF);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 oe", {8'h0, pad_oe}, 16'h0000);
    chk("R1 out", {8'h0, pad_out}, 16'h0000);
    chk("R1 pd", {8'h0, pad_pd}, 16'h00FF);
    rd("R1 dir", 8'h11, 16'h0000);
    rd("R1 idle", 8'h13, 16'h0000);

    pad_in = 8'h3C;
    step();
    rd("R9 one-clock lag", 8'h14, 16'h0000);
    step();
    rd("R9 two-clock lag", 8'h14, 16'h003C);

    wr(8'h10, 16'hFF5A);
    rd("R2 write-only", 8'h10, 16'h0000);
    chk("R8 inputs stay undriven", {pad_out, pad_oe}, 16'h0000);

    wr(8'h11, 16'h0FFF);
    rd("R3 dir readback", 8'h11, 16'h0F00);
    chk("R5 push-pull oe", {8'h0, pad_oe}, 16'h000F);
    chk("R5 push-pull out", {8'h0, pad_out}, 16'h000A);
    chk("R7 pulldown idle", {8'h0, pad_pd}, 16'h00F0);

    wr(8'h12, 16'hFF33);
    rd("R4 drive readback", 8'h12, 16'h0033);
    chk("R6 open-drain oe", {8'h0, pad_oe}, 16'h000D);
    chk("R6 open-drain out", {8'h0, pad_out}, 16'h0008);
    chk("R7 pd after od", {8'h0, pad_pd}, 16'h00F2);

    wr(8'h13, 16'h00F0);
    rd("R7 idle readback", 8'h13, 16'h00F0);
    chk("R7 hiz", {8'h0, pad_pd}, 16'h0002);

    wr(8'h14, 16'hFFFF);
    rd("R10 level reg not writable", 8'h14, 16'h003C);
    wr(8'h20, 16'hFFFF);
    rd("R10 dir untouched", 8'h11, 16'h0F00);
    rd("R10 drive untouched", 8'h12, 16'h0033);
    chk("R10 pads untouched", {8'h0, pad_oe}, 16'h000D);
    rd("R10 unmapped read", 8'h20, 16'h0000);
    rd("R10 unmapped read 0x15", 8'h15, 16'h0000);

    pad_in = 8'h0D;
    step(); step();
    rd("R9 output pins readback", 8'h14, 16'h000D);

    bus_addr = 8'h11; bus_we = 1'b1; bus_wdata = 16'hF000;
    #1;
    chk("R11 before edge", {8'h0, pad_oe}, 16'h000D);
    step();
    bus_we = 1'b0;
    chk("R11 after edge oe", {8'h0, pad_oe}, 16'h00E0);
    chk("R11 after edge out", {8'h0, pad_out}, 16'h0040);
    chk("R11 after edge pd", {8'h0, pad_pd}, 16'h000F);

    for (int k = 0; k < 400; k++) begin
      bus_addr  = 8'h0E + 8'($urandom_range(0, 8));
      bus_we    = 1'($urandom_range(0, 1));
      bus_wdata = 16'($urandom);
      pad_in    = 8'($urandom);
      step();
    end
    bus_we = 1'b0;
    step();
    finish_run();
  end
endmodule